// File: doc/BRIEF.md
# Sign-Magnitude Stochastic Multiply-Accumulate Unit

This block forms a dot product of signed stochastic operands held in sign-magnitude form. Each operand is one sign bit plus a magnitude bitstream whose value is the share of ones among its magnitude bits. The stream arrives as parallel words of `WORD_W` bits per cycle. For each word the two magnitude words are combined position by position with AND, and the ones in the product word are counted. The product sign is fixed once per operand pair, from the two sign bits given with the pair's first word. That sign decides whether the count is added to or subtracted from a saturating two's-complement accumulator.

A caller streams the words of one operand pair after another, marking the first word of each pair, and reads the running binary result on the accumulator output. Idle cycles are allowed anywhere. A synchronous clear starts a new dot product.

Top module: `smsc_mac_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator is loaded with zero, so `acc_o` reads 0 after reset.
- R2: For each valid word of a positive product, the accumulator grows by the number of bit positions where both `mag_a_i` and `mag_b_i` are 1 (bitwise AND, never XNOR).
- R3: The product sign is `sign_a_i XOR sign_b_i`, taken from the word that has `first_i` = 1. A sign of 1 means negative, and a negative product subtracts its count.
- R4: Words of a pair that have `first_i` = 0 reuse the sign latched at the pair's first word, and their sign inputs are ignored.
- R5: A word sampled at rising edge k changes `acc_o` at rising edge k+1. The front stage holds one registered count.
- R6: A cycle with `vld_i` = 0 adds nothing. Its magnitude, sign and first inputs have no effect on `acc_o`.
- R7: A sum above 2^(ACC_W-1)-1 clamps to 2^(ACC_W-1)-1.
- R8: A sum below -2^(ACC_W-1) clamps to -2^(ACC_W-1).
- R9: When `clr_i` is high at an edge, `acc_o` becomes 0 at that edge. The word captured at the previous edge and any word presented with the clear are both discarded.
- R10: A negative product whose count is zero (negative zero) leaves `acc_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of the accumulator and the word in flight |
| vld_i | input | 1 | Qualifies the current magnitude words |
| first_i | input | 1 | Marks the first word of an operand pair |
| sign_a_i | input | 1 | Sign of operand A (1 = negative), used with `first_i` |
| sign_b_i | input | 1 | Sign of operand B (1 = negative), used with `first_i` |
| mag_a_i | input | WORD_W | Magnitude bits of operand A for this cycle |
| mag_b_i | input | WORD_W | Magnitude bits of operand B for this cycle |
| acc_o | output | ACC_W | Signed two's-complement accumulator |

## Verification
Two things can fall on the same edge: a clear, and the accumulate of a count that is already registered in the front stage. A further word may also be presented together with the clear. The bench provokes this by asserting `clr_i` one cycle after a valid word while a second word is offered, and again inside random traffic. A cycle-accurate behavioural model decides the result: the clear must win, and both words must be lost. Saturation meeting a subtraction is also exercised, by sending long runs of all-ones words into both clamp limits.

// File: rtl/smsc_pkg.sv
package smsc_pkg;

    typedef enum logic {
        SGN_POS = 1'b0,
        SGN_NEG = 1'b1
    } sgn_e;

    function automatic int cnt_bits(input int w);
        return $clog2(w + 1);
    endfunction

    function automatic sgn_e prod_sign(input logic sa, input logic sb);
        return sgn_e'(sa ^ sb);
    endfunction

endpackage

// File: rtl/smsc_popcnt.sv
module smsc_popcnt #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] cnt_o
);
    localparam int HALF = W / 2;

    generate
        if (W == 1) begin : g_leaf
            assign cnt_o = CW'(bits_i[0]);
        end else begin : g_split
            logic [CW-1:0] lo_cnt;
            logic [CW-1:0] hi_cnt;
            smsc_popcnt #(.W(HALF), .CW(CW)) lo_i (
                .bits_i(bits_i[HALF-1:0]),
                .cnt_o (lo_cnt)
            );
            smsc_popcnt #(.W(W - HALF), .CW(CW)) hi_i (
                .bits_i(bits_i[W-1:HALF]),
                .cnt_o (hi_cnt)
            );
            assign cnt_o = lo_cnt + hi_cnt;
        end
    endgenerate

endmodule

// File: rtl/smsc_front.sv
module smsc_front
    import smsc_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int CW     = cnt_bits(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              vld,
    input  logic              first,
    input  logic              sa,
    input  logic              sb,
    input  logic [WORD_W-1:0] ma,
    input  logic [WORD_W-1:0] mb,
    output logic              st_vld,
    output sgn_e              st_neg,
    output logic [CW-1:0]     st_cnt
);
    logic [WORD_W-1:0] prod_w;
    logic [CW-1:0]     cnt_w;
    sgn_e              held_q;
    sgn_e              word_sgn;

    assign prod_w   = ma & mb;
    assign word_sgn = first ? prod_sign(sa, sb) : held_q;

    smsc_popcnt #(.W(WORD_W), .CW(CW)) cnt_i (
        .bits_i(prod_w),
        .cnt_o (cnt_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= SGN_POS;
            st_vld <= 1'b0;
            st_neg <= SGN_POS;
            st_cnt <= '0;
        end else begin
            if (vld && first) begin
                held_q <= prod_sign(sa, sb);
            end
            st_vld <= vld && !clr;
            st_neg <= word_sgn;
            st_cnt <= cnt_w;
        end
    end

endmodule

// File: rtl/smsc_sat_acc.sv
module smsc_sat_acc
    import smsc_pkg::*;
#(
    parameter int CW    = 4,
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_vld,
    input  sgn_e             in_neg,
    input  logic [CW-1:0]    in_cnt,
    output logic [ACC_W-1:0] acc_o
);
    localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W:0]   ext;
    logic [ACC_W:0]   delta;
    logic [ACC_W:0]   sum;
    logic [ACC_W-1:0] nxt;

    always_comb begin
        ext   = {acc_o[ACC_W-1], acc_o};
        delta = {{(ACC_W+1-CW){1'b0}}, in_cnt};
        if (in_neg == SGN_NEG) begin
            delta = ~delta + 1'b1;
        end
        sum = ext + delta;
        if (sum[ACC_W] != sum[ACC_W-1]) begin
            nxt = sum[ACC_W] ? MINV : MAXV;
        end else begin
            nxt = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_o <= '0;
        end else if (in_vld) begin
            acc_o <= nxt;
        end
    end

endmodule

// File: rtl/smsc_mac_unit.sv
module smsc_mac_unit
    import smsc_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ACC_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              vld_i,
    input  logic              first_i,
    input  logic              sign_a_i,
    input  logic              sign_b_i,
    input  logic [WORD_W-1:0] mag_a_i,
    input  logic [WORD_W-1:0] mag_b_i,
    output logic [ACC_W-1:0]  acc_o
);
    localparam int CW = cnt_bits(WORD_W);

    logic          st_vld;
    sgn_e          st_neg;
    logic [CW-1:0] st_cnt;

    smsc_front #(.WORD_W(WORD_W), .CW(CW)) front_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_i),
        .vld   (vld_i),
        .first (first_i),
        .sa    (sign_a_i),
        .sb    (sign_b_i),
        .ma    (mag_a_i),
        .mb    (mag_b_i),
        .st_vld(st_vld),
        .st_neg(st_neg),
        .st_cnt(st_cnt)
    );

    smsc_sat_acc #(.CW(CW), .ACC_W(ACC_W)) acc_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_i),
        .in_vld(st_vld),
        .in_neg(st_neg),
        .in_cnt(st_cnt),
        .acc_o (acc_o)
    );

endmodule

// File: rtl/smsc_mac_chk.sv
module smsc_mac_chk #(
    parameter int WORD_W = 8,
    parameter int ACC_W  = 12,
    parameter int CW     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_i,
    input logic             vld_i,
    input logic             first_i,
    input logic             sign_a_i,
    input logic             sign_b_i,
    input logic [ACC_W-1:0] acc_o,
    input logic             st_vld,
    input logic             st_neg,
    input logic [CW-1:0]    st_cnt
);
    localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> acc_o == '0);

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        int'(st_cnt) <= WORD_W);

    assert_first_sign_R3: assert property (@(posedge clk) disable iff (rst)
        (vld_i && first_i) |=> st_neg == $past(sign_a_i ^ sign_b_i));

    assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((int'($signed(acc_o)) - int'($signed($past(acc_o)))) <= WORD_W &&
                    (int'($signed(acc_o)) - int'($signed($past(acc_o)))) >= -WORD_W));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!st_vld && !clr_i) |=> $stable(acc_o));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_o == MAXV && !st_neg && !clr_i) |=> acc_o == MAXV);

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_o == MINV && st_neg && !clr_i) |=> acc_o == MINV);

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> acc_o == '0);

    assert_clear_drop_R9: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !st_vld);

endmodule

bind smsc_mac_unit smsc_mac_chk #(
    .WORD_W(WORD_W),
    .ACC_W (ACC_W),
    .CW    (CW)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (clr_i),
    .vld_i   (vld_i),
    .first_i (first_i),
    .sign_a_i(sign_a_i),
    .sign_b_i(sign_b_i),
    .acc_o   (acc_o),
    .st_vld  (st_vld),
    .st_neg  (st_neg),
    .st_cnt  (st_cnt)
);

// File: tb/smsc_mac_unit_tb_top.sv
module smsc_mac_unit_tb_top;
    localparam int CLK_P  = 10;
    localparam int WORD_W = 8;
    localparam int ACC_W  = 12;
    localparam int MAXI   = (1 << (ACC_W - 1)) - 1;
    localparam int MINI   = -(1 << (ACC_W - 1));

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr = 1'b0;
    logic              vld = 1'b0;
    logic              first = 1'b0;
    logic              sa = 1'b0;
    logic              sb = 1'b0;
    logic [WORD_W-1:0] ma = '0;
    logic [WORD_W-1:0] mb = '0;
    logic [ACC_W-1:0]  acc;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";

    int   m_acc = 0;
    logic m_vld = 1'b0;
    int   m_cnt = 0;
    logic m_neg = 1'b0;
    logic m_held = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    smsc_mac_unit #(.WORD_W(WORD_W), .ACC_W(ACC_W)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr),
        .vld_i   (vld),
        .first_i (first),
        .sign_a_i(sa),
        .sign_b_i(sb),
        .mag_a_i (ma),
        .mag_b_i (mb),
        .acc_o   (acc)
    );

    function automatic int ones(input logic [WORD_W-1:0] w);
        int n = 0;
        for (int i = 0; i < WORD_W; i++) n += int'(w[i]);
        return n;
    endfunction

    // behavioural reference, one update per rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0; m_vld = 1'b0; m_cnt = 0; m_neg = 1'b0; m_held = 1'b0;
        end else begin
            if (clr) m_acc = 0;
            else if (m_vld) begin
                m_acc = m_neg ? m_acc - m_cnt : m_acc + m_cnt;
                if (m_acc > MAXI) m_acc = MAXI;
                if (m_acc < MINI) m_acc = MINI;
            end
            m_vld = vld && !clr;
            m_cnt = ones(ma & mb);
            m_neg = first ? (sa ^ sb) : m_held;
            if (vld && first) m_held = sa ^ sb;
        end
    end

    task automatic check_val(input string req, input int exp_v);
        checks++;
        if (int'($signed(acc)) != exp_v) begin
            failures++;
            $display("FAIL %s acc actual=%0d expected=%0d", req, int'($signed(acc)), exp_v);
        end
    endtask

    // one cycle: compare at the falling edge, then drive the next inputs
    task automatic cyc(input logic v, input logic f, input logic a_s, input logic b_s,
                       input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
                       input logic c);
        @(negedge clk);
        if (!rst) check_val(cur_req, m_acc);
        vld = v; first = f; sa = a_s; sb = b_s; ma = a; mb = b; clr = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int held_v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_val("R1", 0);

        // R2: positive pair, several patterns
        cur_req = "R2";
        cyc(1, 1, 0, 0, 8'hFF, 8'h0F, 0);
        cyc(1, 0, 0, 0, 8'hAA, 8'hFF, 0);
        cyc(1, 0, 0, 0, 8'hF0, 8'h3C, 0);
        cyc(1, 0, 0, 0, 8'h55, 8'hAA, 0);
        cur_req = "R5";
        cyc(0, 0, 0, 0, 8'h00, 8'h00, 0);
        @(negedge clk);
        check_val("R5", 4 + 4 + 2 + 0);

        // R3 then R4: negative pair, later words with flipped sign inputs
        cur_req = "R3";
        cyc(1, 1, 1, 0, 8'hFF, 8'h07, 0);
        cur_req = "R4";
        cyc(1, 0, 0, 0, 8'h0F, 8'h0F, 0);
        cyc(1, 0, 1, 1, 8'h01, 8'h01, 0);
        idle(2);
        check_val("R4", 10 - 3 - 4 - 1);

        // R3: both negative gives positive
        cur_req = "R3";
        cyc(1, 1, 1, 1, 8'h03, 8'h03, 0);
        idle(2);
        check_val("R3", 2 + 2);

        // R6: stall cycles with garbage
        cur_req = "R6";
        cyc(0, 1, 1, 0, 8'hFF, 8'hFF, 0);
        cyc(0, 0, 0, 1, 8'hFF, 8'hFF, 0);
        idle(2);
        check_val("R6", 4);

        // R10: negative zero
        cur_req = "R10";
        cyc(1, 1, 0, 1, 8'hFF, 8'h00, 0);
        idle(2);
        check_val("R10", 4);

        // R9: clear with a word in flight and a word presented
        cur_req = "R9";
        cyc(1, 1, 0, 0, 8'hFF, 8'hFF, 0);
        cyc(1, 0, 0, 0, 8'hFF, 8'hFF, 1);
        cyc(0, 0, 0, 0, 8'h00, 8'h00, 0);
        idle(2);
        check_val("R9", 0);

        // R7: saturate high
        cur_req = "R7";
        cyc(1, 1, 0, 0, 8'hFF, 8'hFF, 0);
        for (int i = 0; i < 280; i++) cyc(1, 0, 1, 0, 8'hFF, 8'hFF, 0);
        idle(2);
        check_val("R7", MAXI);

        // R8: saturate low
        cur_req = "R8";
        cyc(1, 1, 0, 1, 8'hFF, 8'hFF, 0);
        for (int i = 0; i < 540; i++) cyc(1, 0, 0, 0, 8'hFF, 8'hFF, 0);
        idle(2);
        check_val("R8", MINI);

        // mixed random traffic, clears included, compared each cycle
        cur_req = "R2";
        for (int i = 0; i < 600; i++) begin
            cyc(($urandom % 4) != 0, ($urandom % 5) == 0, 1'($urandom), 1'($urandom),
                8'($urandom), 8'($urandom), ($urandom % 40) == 0);
        end
        cur_req = "R9";
        idle(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule